// File: doc/BRIEF.md
# Toeplitz RSS hash selector

This block computes a Toeplitz receive-side-scaling hash over the flow tuple of a received packet and turns the result into a group tag. The tuple (addresses and ports, already extracted upstream) arrives one byte per cycle, with a start marker on the first byte and a last marker on the final byte. For every tuple bit that is 1, the block XORs a 32-bit window of the secret key into an accumulator. The window slides one bit per tuple bit.

A 40-byte secret key is held in ten 32-bit key registers. Byte 0 of the key gives the most significant bits of the first window. The six low bits of the finished hash select one entry of a 64-entry indirection table, and that entry is the group tag. A mode bit turns hashing on. While the mode bit is clear, no result is produced. One cycle after the last tuple byte, the hash and the tag are presented together with a one-cycle valid pulse.

Top module: `rss_hash_sel`

## Requirements
- R1: After reset, outValid is 0, the mode bit is clear, and all key words and table entries are 0.
- R2: A write to byte offset 4*k (k = 0..9) loads key word k. The least significant byte of word k is key byte 4*k and its most significant byte is key byte 4*k+3. Key byte 0, most significant bit first, supplies the leading bits of the first window.
- R3: hashOut equals the XOR, over every tuple bit position p (byte 0 bit 7 is p = 0) whose bit is 1, of key bits p..p+31. For the well-known key over the IPv4/TCP tuples 66.9.149.187:2794 to 161.142.100.80:1766 and 199.92.111.2:14230 to 65.69.140.83:4739, the results are 0x51ccc178 and 0xc626b0ea.
- R4: outValid pulses for one cycle, in the cycle after a byte with inValid and inLast. hashOut and tagOut hold their values until the next result.
- R5: tagOut equals the table entry indexed by hashOut[5:0].
- R6: A byte with inValid and inStart restarts accumulation from zero at the start of the key, so a partly sent earlier tuple has no effect.
- R7: Bit 0 of the mode register at byte offset 0x30 enables hashing. While it is 0, a last byte raises no outValid and leaves hashOut and tagOut unchanged.
- R8: A write to byte offset 0x40+i (i = 0..63) loads table entry i from regWdata[TAG_W-1:0]. A table write in the same cycle as a last byte affects only later tuples.
- R9: A single-byte tuple (inStart and inLast together) is hashed correctly.
- R10: Cycles with inValid low are ignored whatever inByte carries, so bubbles inside a tuple do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| inValid | input | 1 | Tuple byte present |
| inStart | input | 1 | First byte of tuple |
| inLast | input | 1 | Final byte of tuple |
| inByte | input | 8 | Tuple byte |
| outValid | output | 1 | Result pulse |
| hashOut | output | 32 | Toeplitz hash |
| tagOut | output | TAG_W | Group tag from indirection table |

## Verification
Two functions can meet in one cycle: a register write and the hashing of a final tuple byte. The bench provokes this by writing the very table entry that the tuple will select in the same cycle as its last byte. It then requires the reported tag to be the old entry, and the next send of the same tuple to return the new one. It also disables the mode bit and expects silence. All hashes, including the published vectors, are compared against a bit-serial reference computed in the bench over sweeps of tuple lengths, all 256 single-byte tuples, restarts and bubbles.

// File: rtl/rss_pkg.sv
package rss_pkg;
  parameter int KEY_WORDS  = 10;
  parameter int KEY_IDX_W  = $clog2(KEY_WORDS);
  parameter int TBL_IDX_W  = 6;
  parameter int KEY_BITS   = 32 * KEY_WORDS;
  parameter int TBL_DEPTH  = 1 << TBL_IDX_W;

  typedef struct packed {
    logic                 keyWe;
    logic [KEY_IDX_W-1:0] keyIdx;
    logic                 tblWe;
    logic [TBL_IDX_W-1:0] tblIdx;
    logic                 restart;
    logic                 step;
    logic                 capture;
  } dpCtrlT;
endpackage

// File: rtl/rss_ctrl.sv
module rss_ctrl
  import rss_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              modeBit,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inLast,
  output dpCtrlT            ctl,
  output logic              outValid
);
  localparam int REGION_W = ADDR_W - TBL_IDX_W;

  logic modeOn;
  logic keyHit, tblHit, modeHit;

  always_comb begin
    keyHit  = regWe && (regAddr[ADDR_W-1:TBL_IDX_W] == '0) && (regAddr[1:0] == 2'b00)
              && (32'(regAddr[TBL_IDX_W-1:2]) < KEY_WORDS);
    tblHit  = regWe && (regAddr[ADDR_W-1:TBL_IDX_W] == REGION_W'(1));
    modeHit = regWe && (regAddr == MODE_ADDR);

    ctl.keyWe   = keyHit;
    ctl.keyIdx  = KEY_IDX_W'(regAddr[TBL_IDX_W-1:2]);
    ctl.tblWe   = tblHit;
    ctl.tblIdx  = regAddr[TBL_IDX_W-1:0];
    ctl.step    = inValid;
    ctl.restart = inValid && inStart;
    ctl.capture = inValid && inLast && modeOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeOn   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (modeHit) modeOn <= modeBit;
      outValid <= ctl.capture;
    end
  end
endmodule

// File: rtl/rss_dp.sv
module rss_dp
  import rss_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrlT           ctl,
  input  logic [31:0]      regWdata,
  input  logic [7:0]       inByte,
  output logic [31:0]      hashOut,
  output logic [TAG_W-1:0] tagOut
);
  logic [31:0]         keyReg [KEY_WORDS];
  logic [TAG_W-1:0]    tbl    [TBL_DEPTH];
  logic [KEY_BITS-1:0] keyFlat, keyShift, curKey;
  logic [31:0]         acc, nextAcc;

  // key byte 4k+i sits in bits [8i+7:8i] of word k; byte 0 lands at the top
  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_word
    for (genvar i = 0; i < 4; i++) begin : g_byte
      assign keyFlat[KEY_BITS-1-8*(4*k+i) -: 8] = keyReg[k][8*i+7 -: 8];
    end
  end

  always_comb begin
    curKey  = ctl.restart ? keyFlat : keyShift;
    nextAcc = ctl.restart ? 32'h0 : acc;
    for (int j = 0; j < 8; j++) begin
      if (inByte[7-j]) nextAcc = nextAcc ^ curKey[KEY_BITS-1-j -: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < KEY_WORDS; k++) keyReg[k] <= '0;
      for (int t = 0; t < TBL_DEPTH; t++) tbl[t] <= '0;
      keyShift <= '0;
      acc      <= '0;
      hashOut  <= '0;
      tagOut   <= '0;
    end else begin
      if (ctl.keyWe) keyReg[ctl.keyIdx] <= regWdata;
      if (ctl.tblWe) tbl[ctl.tblIdx] <= regWdata[TAG_W-1:0];
      if (ctl.step) begin
        acc      <= nextAcc;
        keyShift <= curKey << 8;
      end
      if (ctl.capture) begin
        hashOut <= nextAcc;
        tagOut  <= tbl[nextAcc[TBL_IDX_W-1:0]];
      end
    end
  end
endmodule

// File: rtl/rss_hash_sel.sv
module rss_hash_sel
  import rss_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inLast,
  input  logic [7:0]        inByte,
  output logic              outValid,
  output logic [31:0]       hashOut,
  output logic [TAG_W-1:0]  tagOut
);
  dpCtrlT ctl;

  rss_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .modeBit(regWdata[0]), .inValid(inValid), .inStart(inStart),
    .inLast(inLast), .ctl(ctl), .outValid(outValid)
  );

  rss_dp #(.TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regWdata(regWdata),
    .inByte(inByte), .hashOut(hashOut), .tagOut(tagOut)
  );
endmodule

// File: rtl/rss_hash_sel_chk.sv
module rss_hash_sel_chk #(
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic              inValid,
  input logic              inLast,
  input logic              outValid,
  input logic [31:0]       hashOut,
  input logic [TAG_W-1:0]  tagOut
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid);

  a_r4_valid_needs_last: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && inLast));

  a_r4_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(hashOut) && $stable(tagOut)));

  a_r7_mode_off_silent: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(8'h30) && !regWdata[0]) ##1 (inValid && inLast && !regWe)
      |=> !outValid);

  a_r3_hash_known: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !$isunknown({hashOut, tagOut}));
endmodule

bind rss_hash_sel rss_hash_sel_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .inValid(inValid), .inLast(inLast), .outValid(outValid),
  .hashOut(hashOut), .tagOut(tagOut)
);

// File: tb/sim_rss_hash_sel.sv
`timescale 1ns/1ps
module sim_rss_hash_sel;
  localparam int TAG_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic inValid = 1'b0, inStart = 1'b0, inLast = 1'b0;
  logic [7:0] inByte = '0;
  logic outValid;
  logic [31:0] hashOut;
  logic [TAG_W-1:0] tagOut;

  int checks = 0, errors = 0;
  logic [7:0] keyB [40];
  logic [TAG_W-1:0] expTbl [64];
  logic [7:0] tup [40];
  logic [31:0] seed = 32'h1d2c3b4a;
  bit coWr = 0; logic [7:0] coAddr; logic [31:0] coData;

  always #4 clk = ~clk;

  rss_hash_sel #(.TAG_W(TAG_W), .ADDR_W(8)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .inValid(inValid), .inStart(inStart), .inLast(inLast), .inByte(inByte),
    .outValid(outValid), .hashOut(hashOut), .tagOut(tagOut)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic keyBit(int q);
    return keyB[q/8][7 - (q%8)];
  endfunction

  function automatic logic [31:0] refHash(int len);
    logic [31:0] h = 0;
    for (int p = 0; p < 8*len; p++) begin
      if (tup[p/8][7 - (p%8)]) begin
        logic [31:0] w = 0;
        for (int b = 0; b < 32; b++) w[31-b] = keyBit(p + b);
        h = h ^ w;
      end
    end
    return h;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic loadKey();
    for (int k = 0; k < 10; k++)
      regWrite(8'(4*k), {keyB[4*k+3], keyB[4*k+2], keyB[4*k+1], keyB[4*k]});
  endtask

  // leaves the negedge after the result cycle current
  task automatic sendTuple(int len, bit gap);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      inValid = 1; inStart = (b == 0); inLast = (b == len-1); inByte = tup[b];
      if (coWr && b == len-1) begin regWe = 1; regAddr = coAddr; regWdata = coData; end
      if (gap && b != len-1) begin
        @(negedge clk);
        inValid = 0; inStart = 1; inLast = 1; inByte = rnd()[7:0];
      end
    end
    @(negedge clk);
    inValid = 0; inStart = 0; inLast = 0; regWe = 0; coWr = 0;
  endtask

  task automatic runCheck(string req, int len, bit gap);
    logic [31:0] e;
    e = refHash(len);
    sendTuple(len, gap);
    chk({req, " valid"}, 32'(outValid), 1);
    chk({req, " hash"}, hashOut, e);
    chk({req, " R5 tag"}, 32'(tagOut), 32'(expTbl[e[5:0]]));
  endtask

  task automatic setV1();
    logic [7:0] v [12] = '{8'h42,8'h09,8'h95,8'hbb,8'ha1,8'h8e,8'h64,8'h50,8'h0a,8'hea,8'h06,8'he6};
    for (int i = 0; i < 12; i++) tup[i] = v[i];
  endtask

  task automatic setV2();
    logic [7:0] v [12] = '{8'hc7,8'h5c,8'h6f,8'h02,8'h41,8'h45,8'h8c,8'h53,8'h37,8'h96,8'h12,8'h83};
    for (int i = 0; i < 12; i++) tup[i] = v[i];
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] kinit [40] = '{
      8'h6d,8'h5a,8'h56,8'hda,8'h25,8'h5b,8'h0e,8'hc2,8'h41,8'h67,
      8'h25,8'h3d,8'h43,8'ha3,8'h8f,8'hb0,8'hd0,8'hca,8'h2b,8'hcb,
      8'hae,8'h7b,8'h30,8'hb4,8'h77,8'hcb,8'h2d,8'ha3,8'h80,8'h30,
      8'hf2,8'h0c,8'h6a,8'h42,8'hb7,8'h3b,8'hbe,8'hac,8'h01,8'hfa};
    logic [31:0] h1;
    for (int i = 0; i < 40; i++) keyB[i] = kinit[i];
    for (int i = 0; i < 64; i++) expTbl[i] = TAG_W'(i*5 + 3);

    repeat (3) @(negedge clk);
    chk("R1 outValid in reset", 32'(outValid), 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 outValid after reset", 32'(outValid), 0);
    chk("R1 hash after reset", hashOut, 0);

    // R7: mode clear by default -> no result
    setV1(); sendTuple(12, 0);
    chk("R7 no valid at reset mode", 32'(outValid), 0);
    chk("R7 hash unchanged", hashOut, 0);

    loadKey();
    for (int i = 0; i < 64; i++) regWrite(8'(8'h40 + i), 32'(expTbl[i]));
    regWrite(8'h30, 32'h1);

    // R3/R2 published vectors
    setV1(); runCheck("R3 R2 vector1", 12, 0);
    chk("R3 published vector1", hashOut, 32'h51ccc178);
    h1 = hashOut;
    @(negedge clk);
    chk("R4 single-cycle pulse", 32'(outValid), 0);
    chk("R4 hash held", hashOut, h1);
    setV2(); runCheck("R3 vector2", 12, 0);
    chk("R3 published vector2", hashOut, 32'hc626b0ea);

    // R10: bubbles with garbage bytes
    setV1(); runCheck("R10 bubbles", 12, 1);

    // sweep lengths, with and without bubbles
    for (int len = 1; len <= 36; len++) begin
      for (int r = 0; r < 3; r++) begin
        for (int i = 0; i < len; i++) tup[i] = rnd()[7:0];
        runCheck(len == 1 ? "R9 sweep" : "R3 sweep", len, r == 2);
      end
    end

    // R9: all single-byte tuples
    for (int v = 0; v < 256; v++) begin
      tup[0] = 8'(v);
      runCheck("R9 single byte", 1, 0);
    end

    // R6: abandoned partial tuple then restart
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); inValid = 1; inStart = (i == 0); inLast = 0; inByte = rnd()[7:0];
    end
    @(negedge clk); inValid = 0;
    for (int i = 0; i < 12; i++) tup[i] = rnd()[7:0];
    runCheck("R6 restart", 12, 0);

    // R8: table write collides with last byte -> old tag now, new tag next time
    setV1();
    h1 = refHash(12);
    coWr = 1; coAddr = 8'(8'h40 + h1[5:0]); coData = 32'(~expTbl[h1[5:0]]);
    runCheck("R8 same-cycle write uses old entry", 12, 0);
    expTbl[h1[5:0]] = ~expTbl[h1[5:0]];
    runCheck("R8 new entry used", 12, 0);

    // R2: replace key word 0 and word 9, reference follows byte mapping
    keyB[0] = 8'h78; keyB[1] = 8'h56; keyB[2] = 8'h34; keyB[3] = 8'h12;
    keyB[36] = 8'h9a; keyB[37] = 8'hbc; keyB[38] = 8'hde; keyB[39] = 8'hf0;
    regWrite(8'h00, 32'h12345678);
    regWrite(8'h24, 32'hf0debc9a);
    for (int i = 0; i < 36; i++) tup[i] = rnd()[7:0];
    runCheck("R2 rewritten key", 36, 0);
    setV1(); runCheck("R2 rewritten key short", 12, 0);

    // R7: disable again, result registers unchanged
    h1 = hashOut;
    regWrite(8'h30, 32'h0);
    setV2(); sendTuple(12, 0);
    chk("R7 disabled no valid", 32'(outValid), 0);
    chk("R7 disabled hash held", hashOut, h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule